// File: doc/BRIEF.md
# Wake-up interrupt controller

This block keeps watch over the interrupt request lines while the processor clocks are stopped. It runs on a small always-on clock. When the processor goes into one of its low-power states, it pulses a sleep-entry strobe. On that strobe the block takes a snapshot of which interrupts may wake the core. An interrupt qualifies when it is enabled and also has enough priority to be serviced at once. The main interrupt controller supplies both qualifiers as per-line vectors.

While the snapshot is held, any qualifying interrupt line that goes active is latched into a sticky per-line flag, and the single wake request output rises. The request stays high until the power controller acknowledges the wake. The acknowledge drops the request, empties the snapshot and returns the block to idle. The core never has to wake on a timer to poll its interrupts. Priority arbitration and vectoring stay in the main interrupt controller.

Top module: `wake_irq_ctrl`

## Requirements
- R1: After synchronous reset, `wake_req` is 0 and the snapshot is empty. Active interrupts with no sleep entry do not raise `wake_req`.
- R2: When `sleep_entry` is sampled high while idle and `wake_ack` is low, the snapshot becomes `irq_en & irq_prio_ok`, taken bit by bit.
- R3: While sleeping, `wake_req` is high after the first clock edge at which some `irq` bit is high and its snapshot bit is set. This holds for every line, 0 through NUM_IRQ-1.
- R4: If a qualifying interrupt (`irq & irq_en & irq_prio_ok` non-zero) is already active at the edge that samples `sleep_entry`, `wake_req` is high after that same edge.
- R5: An interrupt whose snapshot bit is clear never raises `wake_req`, however long it stays active.
- R6: Once high, `wake_req` stays high until `wake_ack` is sampled, even if the interrupt that caused it has gone away (a one-cycle pulse is not lost).
- R7: Sampling `wake_ack` high makes `wake_req` 0 after that edge and empties the snapshot. Later interrupts do not raise `wake_req` until a new sleep entry.
- R8: Changes to `irq_en` and `irq_prio_ok` after sleep entry have no effect. Only the snapshot decides which lines wake the core.
- R9: `sleep_entry` is ignored while the block is already sleeping or waking. When `sleep_entry` and `wake_ack` are sampled in the same cycle, the acknowledge wins and no snapshot is taken.
- R10: While idle, no interrupt activity raises `wake_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | NUM_IRQ | Level-sensitive interrupt requests |
| irq_en | input | NUM_IRQ | Per-line enable state from the interrupt controller |
| irq_prio_ok | input | NUM_IRQ | Per-line flag: priority high enough to be serviced at once |
| sleep_entry | input | 1 | One-cycle strobe on entry into a low-power state |
| wake_ack | input | 1 | Acknowledge of the wake request; clears the block |
| wake_req | output | 1 | Registered wake request to the power controller |

## Verification
Every result of this block is due one clock edge after the inputs that cause it. `wake_req` reflects the sleep strobe, the interrupt levels and the acknowledge that were sampled at the preceding rising edge. The bench drives all inputs at the falling edge and samples `wake_req` 1 ns after the next rising edge. Each directed check therefore compares against the response to exactly one stimulus cycle. In the random phase, a bench reference model is stepped with the same inputs at the same edge and compared every cycle.

// File: rtl/wic_pkg.sv
package wic_pkg;

  typedef enum logic [1:0] {
    WIC_IDLE  = 2'd0,
    WIC_ARMED = 2'd1,
    WIC_WAKE  = 2'd2
  } wic_state_e;

endpackage

// File: rtl/wic_mask_latch.sv
module wic_mask_latch #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               capture,
  input  logic               clear,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_IRQ-1:0] irq_prio_ok,
  output logic [NUM_IRQ-1:0] mask,
  output logic [NUM_IRQ-1:0] qual
);

  logic [NUM_IRQ-1:0] live_qual;

  assign live_qual = irq_en & irq_prio_ok;
  // During the capture cycle the live qualifiers stand in for the snapshot.
  assign qual = capture ? live_qual : mask;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      mask <= '0;
    end else if (capture) begin
      mask <= live_qual;
    end
  end

  AST_SNAPSHOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (capture && !clear) |=> (mask == $past(irq_en & irq_prio_ok))); // R2

  AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!capture && !clear) |=> $stable(mask)); // R8

  AST_SNAPSHOT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clear |=> (mask == '0)); // R7

endmodule

// File: rtl/wic_pend_detect.sv
module wic_pend_detect #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               watch,
  input  logic               clear,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic [NUM_IRQ-1:0] qual,
  output logic               any_next
);

  logic [NUM_IRQ-1:0] pend;
  logic [NUM_IRQ-1:0] pend_next;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign pend_next[i] = pend[i] | (watch & irq[i] & qual[i]);

    always_ff @(posedge clk) begin
      if (rst || clear) begin
        pend[i] <= 1'b0;
      end else begin
        pend[i] <= pend_next[i];
      end
    end
  end

  assign any_next = |pend_next;

  AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (watch && !clear && |(irq & qual)) |=> (pend != '0)); // R3

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!clear && pend != '0) |=> (pend != '0)); // R6

endmodule

// File: rtl/wic_seq.sv
module wic_seq
  import wic_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sleep_entry,
  input  logic wake_ack,
  input  logic any_next,
  output logic capture,
  output logic clear,
  output logic watching,
  output logic wake_q
);

  wic_state_e state;
  wic_state_e state_next;

  assign clear    = wake_ack;
  assign capture  = (state == WIC_IDLE) && sleep_entry && !wake_ack;
  assign watching = (state != WIC_IDLE);

  always_comb begin
    state_next = state;
    if (clear) begin
      state_next = WIC_IDLE;
    end else begin
      case (state)
        WIC_IDLE:  if (capture) state_next = any_next ? WIC_WAKE : WIC_ARMED;
        WIC_ARMED: if (any_next) state_next = WIC_WAKE;
        WIC_WAKE:  state_next = WIC_WAKE;
        default:   state_next = WIC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= WIC_IDLE;
      wake_q <= 1'b0;
    end else begin
      state  <= state_next;
      wake_q <= (state_next == WIC_WAKE);
    end
  end

  AST_SLEEP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state != WIC_IDLE && !wake_ack) |=> (state != WIC_IDLE)); // R9

  AST_ACK_WINS: assert property (@(posedge clk) disable iff (rst)
    wake_ack |=> (state == WIC_IDLE)); // R9

endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_IRQ-1:0] irq_prio_ok,
  input  logic               sleep_entry,
  input  logic               wake_ack,
  output logic               wake_req
);

  logic               capture;
  logic               clear;
  logic               watching;
  logic               any_next;
  logic [NUM_IRQ-1:0] mask;
  logic [NUM_IRQ-1:0] qual;

  wic_seq i_seq (
    .clk         (clk),
    .rst         (rst),
    .sleep_entry (sleep_entry),
    .wake_ack    (wake_ack),
    .any_next    (any_next),
    .capture     (capture),
    .clear       (clear),
    .watching    (watching),
    .wake_q      (wake_req)
  );

  wic_mask_latch #(.NUM_IRQ(NUM_IRQ)) i_mask (
    .clk         (clk),
    .rst         (rst),
    .capture     (capture),
    .clear       (clear),
    .irq_en      (irq_en),
    .irq_prio_ok (irq_prio_ok),
    .mask        (mask),
    .qual        (qual)
  );

  wic_pend_detect #(.NUM_IRQ(NUM_IRQ)) i_pend (
    .clk      (clk),
    .rst      (rst),
    .watch    (capture | watching),
    .clear    (clear),
    .irq      (irq),
    .qual     (qual),
    .any_next (any_next)
  );

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    wake_ack |=> !wake_req); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (wake_req && !wake_ack) |=> wake_req); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!watching && !sleep_entry) |=> !wake_req); // R10

  AST_ENTRY_HIT: assert property (@(posedge clk) disable iff (rst)
    (!watching && sleep_entry && !wake_ack && |(irq & irq_en & irq_prio_ok)) |=> wake_req); // R4

  AST_ARMED_HIT: assert property (@(posedge clk) disable iff (rst)
    (watching && !wake_ack && |(irq & mask)) |=> wake_req); // R3

endmodule

// File: tb/test_wake_irq_ctrl.sv
`timescale 1ns/1ps
module test_wake_irq_ctrl;

  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] irq = '0;
  logic [N-1:0] irq_en = '0;
  logic [N-1:0] irq_prio_ok = '0;
  logic         sleep_entry = 1'b0;
  logic         wake_ack = 1'b0;
  logic         wake_req;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int           m_state = 0; // 0 idle, 1 armed, 2 wake
  logic [N-1:0] m_mask = '0;
  logic [N-1:0] m_pend = '0;
  logic         m_wake = 1'b0;

  always #2.5 clk = ~clk;

  wake_irq_ctrl #(.NUM_IRQ(N)) i_wake_irq_ctrl (
    .clk(clk), .rst(rst), .irq(irq), .irq_en(irq_en),
    .irq_prio_ok(irq_prio_ok), .sleep_entry(sleep_entry),
    .wake_ack(wake_ack), .wake_req(wake_req)
  );

  function automatic logic model_any(logic [N-1:0] p);
    return p != '0;
  endfunction

  task automatic model_step();
    if (wake_ack) begin
      m_mask = '0; m_pend = '0; m_state = 0;
    end else if (m_state == 0) begin
      if (sleep_entry) begin
        m_mask  = irq_en & irq_prio_ok;
        m_pend  = irq & m_mask;
        m_state = model_any(m_pend) ? 2 : 1;
      end
    end else begin
      m_pend = m_pend | (irq & m_mask);
      if (model_any(m_pend)) m_state = 2;
    end
    m_wake = (m_state == 2);
  endtask

  task automatic cyc(logic [N-1:0] i, logic [N-1:0] e, logic [N-1:0] p,
                     logic s, logic a);
    @(negedge clk);
    irq = i; irq_en = e; irq_prio_ok = p; sleep_entry = s; wake_ack = a;
    @(posedge clk);
    #1;
    model_step();
  endtask

  task automatic check(string tag, logic exp);
    checks++;
    if (wake_req !== exp) begin
      fails++;
      $display("FAIL %s: wake_req=%b expected=%b", tag, wake_req, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #0.1;
    check("R1 reset value", 1'b0);

    // idle: interrupts without sleep entry
    cyc('1, '1, '1, 0, 0); check("R1 no wake after reset", 1'b0);
    cyc('1, '1, '1, 0, 0); check("R10 idle ignores irq", 1'b0);

    // snapshot en=0x0F prio=0x05 -> mask 0x05
    cyc('0, 32'h0F, 32'h05, 1, 0); check("R2 entry no irq", 1'b0);
    cyc(32'h02, 32'h0F, 32'h05, 0, 0); check("R5 enabled but low priority", 1'b0);
    cyc(32'h0A, 32'h0F, 32'h05, 0, 0); check("R5 masked lines stay quiet", 1'b0);
    cyc(32'h04, 32'h0F, 32'h05, 0, 0); check("R3 masked-in line wakes", 1'b1);
    cyc('0, '0, '0, 0, 0); check("R6 held after pulse", 1'b1);
    cyc('0, '0, '0, 0, 0); check("R6 still held", 1'b1);
    cyc('0, '1, '1, 1, 0); check("R9 sleep during wake ignored", 1'b1);
    cyc('0, '0, '0, 0, 1); check("R7 ack drops request", 1'b0);
    cyc(32'h04, '1, '1, 0, 0); check("R7 snapshot emptied", 1'b0);

    // snapshot holds against later qualifier changes
    cyc('0, 32'h01, 32'h01, 1, 0); check("R2 snapshot bit0", 1'b0);
    cyc(32'h10, '1, '1, 0, 0); check("R8 new enable has no effect", 1'b0);
    cyc(32'h01, '0, '0, 0, 0); check("R8 dropped enable still wakes", 1'b1);
    cyc('0, '0, '0, 0, 1); check("R7 ack", 1'b0);

    // qualifying interrupt active at entry
    cyc(32'h80, 32'h80, 32'h80, 1, 0); check("R4 wake on entry cycle", 1'b1);
    cyc('0, '0, '0, 0, 1); check("R7 ack", 1'b0);

    // ack and sleep together: ack wins
    cyc('0, '1, '1, 1, 1); check("R9 ack with sleep", 1'b0);
    cyc('1, '1, '1, 0, 0); check("R9 no snapshot taken", 1'b0);

    // sleep while armed ignored
    cyc('0, 32'h01, 32'h01, 1, 0); check("R2 arm bit0", 1'b0);
    cyc('0, 32'h20, 32'h20, 1, 0); check("R9 second entry", 1'b0);
    cyc(32'h20, '0, '0, 0, 0); check("R9 second snapshot ignored", 1'b0);
    cyc(32'h01, '0, '0, 0, 0); check("R3 original snapshot wakes", 1'b1);
    cyc('0, '0, '0, 0, 1); check("R7 ack", 1'b0);

    // top line boundary
    cyc('0, 32'h8000_0000, 32'h8000_0000, 1, 0); check("R2 arm top line", 1'b0);
    cyc(32'h8000_0000, '0, '0, 0, 0); check("R3 top line wakes", 1'b1);
    cyc('0, '0, '0, 0, 1); check("R7 ack", 1'b0);

    // random phase against the model
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] ri, re, rp;
      logic rs, ra;
      ri = '0;
      if ($urandom % 4 == 0) ri[$urandom % N] = 1'b1;
      re = $urandom;
      rp = $urandom;
      rs = ($urandom % 8 == 0);
      ra = m_wake ? ($urandom % 4 == 0) : ($urandom % 40 == 0);
      cyc(ri, re, rp, rs, ra);
      check("R3 R5 R6 R7 random vs model", m_wake);
    end

    finish_run();
  end

endmodule